// File: doc/BRIEF.md
# Locked Bus Sequence Controller

This block sequences the bus lock of a simple processor bus interface and produces the three-bit status code of every transfer. The execution unit gives it three strobes: a decoded lock prefix, the start of a data cycle, and the completion of an instruction. A lock prefix does not lock the bus by itself. It leaves the controller armed. The active-low lock output is driven low only when the first data cycle of the following instruction begins. It stays low until that instruction completes.

While the lock is held, a prefetch-inhibit output is high. Any instruction-fetch request made in that time is not started, and the bus shows the passive code instead. Each clock the bus interface presents a cycle-valid bit and a cycle kind. One clock later the controller shows the matching status code. When no cycle is active, it shows the passive code 111.

Top module: `lock_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `lock_n` is 1, `pf_inhibit` is 0 and `status` is 3'b111. Reset also clears a pending armed lock request.
- R2: A `lock_prefix` pulse by itself never drives `lock_n` low. `lock_n` falls only at the clock edge where `data_start` is sampled high while a request is armed.
- R3: If a request is armed and `data_start` is high without `instr_done` in the same clock, `lock_n` is 0 one clock later.
- R4: Once `lock_n` is low, it stays low until a clock in which `instr_done` is high. One clock after that, `lock_n` is 1.
- R5: An `instr_done` pulse that arrives while a request is armed, with no `lock_prefix` in the same clock, cancels the request. This applies even when `data_start` is high in that clock. A later `data_start` then leaves `lock_n` at 1.
- R6: `pf_inhibit` is high exactly when `lock_n` is low. A fetch request (`cyc_kind` 0) made while the lock is held gives `status` 3'b111 one clock later.
- R7: With `cyc_go` high, `status` one clock later is set by `cyc_kind` as follows: 0 gives 100, 1 gives 101, 2 gives 110, 3 gives 001, 4 gives 010, 5 gives 000, 6 gives 011, and 7 gives 111.
- R8: In a clock where `cyc_go` is low, `status` one clock later is 3'b111, whatever `cyc_kind` is.
- R9: For any data transfer, `status[2]` is 1 for memory and 0 for I/O. `status[1]` is 1 for writes and 0 for reads.
- R10: A `lock_prefix` in the same clock as `instr_done` of a locked instruction releases the current lock and arms a new request. The next `data_start` locks the bus again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_go | input | 1 | A bus cycle is requested in this clock |
| cyc_kind | input | 3 | Requested cycle kind (codes in R7) |
| lock_prefix | input | 1 | Lock prefix decoded |
| data_start | input | 1 | First clock of a data cycle |
| instr_done | input | 1 | Current instruction completes |
| status | output | 3 | Registered bus cycle status code |
| lock_n | output | 1 | Bus lock, active low |
| pf_inhibit | output | 1 | Prefetch suppression, high while locked |

## Verification
Every result is due exactly one clock after the stimulus that causes it. This holds for the status code after a cycle request, for `lock_n` after `data_start` or `instr_done`, and for `pf_inhibit`, which follows `lock_n` in the same cycle. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge, and all three outputs are compared at the next falling edge, so each comparison sees the state one register after its stimulus. The directed sequences place `instr_done`, `data_start` and `lock_prefix` in the same clock to exercise the cases where they compete. A long random phase with occasional resets follows.

// File: rtl/lock_seq_ctrl.sv
module lock_seq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_go,
  input  logic [2:0] cyc_kind,
  input  logic       lock_prefix,
  input  logic       data_start,
  input  logic       instr_done,
  output logic [2:0] status,
  output logic       lock_n,
  output logic       pf_inhibit
);
  localparam logic [2:0] K_FETCH = 3'd0;
  localparam logic [2:0] K_MRD   = 3'd1;
  localparam logic [2:0] K_MWR   = 3'd2;
  localparam logic [2:0] K_IORD  = 3'd3;
  localparam logic [2:0] K_IOWR  = 3'd4;
  localparam logic [2:0] K_INTA  = 3'd5;
  localparam logic [2:0] K_HALT  = 3'd6;

  localparam logic [2:0] ST_INTA  = 3'b000;
  localparam logic [2:0] ST_IORD  = 3'b001;
  localparam logic [2:0] ST_IOWR  = 3'b010;
  localparam logic [2:0] ST_HALT  = 3'b011;
  localparam logic [2:0] ST_FETCH = 3'b100;
  localparam logic [2:0] ST_MRD   = 3'b101;
  localparam logic [2:0] ST_MWR   = 3'b110;
  localparam logic [2:0] ST_IDLE  = 3'b111;

  logic       armed, locked;
  logic [2:0] status_q, code;

  always_comb begin
    case (cyc_kind)
      K_FETCH: code = locked ? ST_IDLE : ST_FETCH;
      K_MRD:   code = ST_MRD;
      K_MWR:   code = ST_MWR;
      K_IORD:  code = ST_IORD;
      K_IOWR:  code = ST_IOWR;
      K_INTA:  code = ST_INTA;
      K_HALT:  code = ST_HALT;
      default: code = ST_IDLE;
    endcase
    if (!cyc_go) code = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      locked   <= 1'b0;
      status_q <= ST_IDLE;
    end else begin
      armed    <= lock_prefix | (armed & ~data_start & ~instr_done);
      locked   <= locked ? ~instr_done : (armed & data_start & ~instr_done);
      status_q <= code;
    end
  end

  assign status     = status_q;
  assign lock_n     = ~locked;
  assign pf_inhibit = locked;
endmodule

// File: rtl/lock_seq_ctrl_chk.sv
module lock_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_go,
  input logic [2:0] cyc_kind,
  input logic       lock_prefix,
  input logic       data_start,
  input logic       instr_done,
  input logic [2:0] status,
  input logic       lock_n,
  input logic       pf_inhibit
);
  // R1
  rst_state_chk: assert property (@(posedge clk) !rst_n |=> (lock_n && !pf_inhibit && status == 3'b111));

  // R2
  fall_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> $past(data_start));

  // R2
  prefix_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_n && lock_prefix && !data_start) |=> lock_n);

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_n && !instr_done) |=> !lock_n);

  // R4
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_n && instr_done) |=> lock_n);

  // R6
  inhibit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_inhibit == !lock_n);

  // R6
  no_fetch_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_n |=> status != 3'b100);

  // R8
  idle_passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_go |=> status == 3'b111);

  // R7
  io_read_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_go && cyc_kind == 3'd3) |=> status == 3'b001);

  // R9
  mem_write_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_go && cyc_kind == 3'd2) |=> (status[2] && status[1]));
endmodule

bind lock_seq_ctrl lock_seq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_go(cyc_go), .cyc_kind(cyc_kind),
  .lock_prefix(lock_prefix), .data_start(data_start), .instr_done(instr_done),
  .status(status), .lock_n(lock_n), .pf_inhibit(pf_inhibit)
);

// File: tb/lock_seq_ctrl_tb.sv
module lock_seq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n, cyc_go, lock_prefix, data_start, instr_done;
  logic [2:0] cyc_kind;
  logic [2:0] status;
  logic lock_n, pf_inhibit;

  always #4 clk = ~clk;

  lock_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_go(cyc_go), .cyc_kind(cyc_kind),
    .lock_prefix(lock_prefix), .data_start(data_start), .instr_done(instr_done),
    .status(status), .lock_n(lock_n), .pf_inhibit(pf_inhibit)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit m_pend, m_held;
  int m_code;

  function automatic int kind_code(input int k);
    int tbl[8] = '{4, 5, 6, 1, 2, 0, 3, 7};
    return tbl[k];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_held = 0; m_code = 7;
    end else begin
      bit old_pend, old_held;
      old_pend = m_pend; old_held = m_held;
      if (!cyc_go) m_code = 7;
      else if (cyc_kind == 3'd0 && old_held) m_code = 7;
      else m_code = kind_code(int'(cyc_kind));
      if (old_held) m_held = !instr_done;
      else m_held = old_pend && data_start && !instr_done;
      if (lock_prefix) m_pend = 1;
      else if (data_start || instr_done) m_pend = 0;
    end
  end

  task automatic compare(input string req);
    n_cmp++;
    if (lock_n !== !m_held) begin
      n_bad++;
      $display("FAIL %s lock_n actual=%b expected=%b", req, lock_n, !m_held);
    end
    n_cmp++;
    if (pf_inhibit !== m_held) begin
      n_bad++;
      $display("FAIL %s pf_inhibit actual=%b expected=%b", req, pf_inhibit, m_held);
    end
    n_cmp++;
    if (status !== 3'(m_code)) begin
      n_bad++;
      $display("FAIL %s status actual=%b expected=%b", req, status, 3'(m_code));
    end
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic quiet();
    cyc_go = 0; cyc_kind = 3'd7; lock_prefix = 0; data_start = 0; instr_done = 0;
  endtask

  task automatic expect_lock(input string req, input bit low);
    n_cmp++;
    if (lock_n !== !low) begin
      n_bad++;
      $display("FAIL %s directed lock_n actual=%b expected=%b", req, lock_n, !low);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog run did not end actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; quiet();
    cyc_go = 1; cyc_kind = 3'd2; lock_prefix = 1; data_start = 1;
    @(negedge clk);
    tick("R1"); tick("R1");
    quiet(); rst_n = 1;
    tick("R1");
    // R1: the armed request made during reset must not lock the bus
    data_start = 1; tick("R1"); expect_lock("R1", 0);
    quiet();

    // R7 R9: each cycle kind gives its status code one clock later
    for (int k = 0; k < 8; k++) begin
      cyc_go = 1; cyc_kind = 3'(k); tick("R7");
    end
    cyc_go = 1; cyc_kind = 3'd1; tick("R9");
    cyc_kind = 3'd4; tick("R9");
    // R8: passive whenever no cycle is requested
    for (int k = 0; k < 8; k++) begin
      cyc_go = 0; cyc_kind = 3'(k); tick("R8");
    end

    // R2 R3: the prefix only arms, the data cycle locks
    quiet(); lock_prefix = 1; tick("R2"); expect_lock("R2", 0);
    quiet(); cyc_go = 1; cyc_kind = 3'd0; tick("R2"); tick("R2");
    cyc_kind = 3'd1; data_start = 1; tick("R3"); expect_lock("R3", 1);
    // R6: a fetch is held off while locked
    quiet(); cyc_go = 1; cyc_kind = 3'd0; tick("R6"); tick("R6");
    // R4: held across further data cycles, released on completion
    quiet(); data_start = 1; cyc_go = 1; cyc_kind = 3'd2; tick("R4"); expect_lock("R4", 1);
    quiet(); tick("R4");
    instr_done = 1; tick("R4"); expect_lock("R4", 0);
    quiet(); cyc_go = 1; cyc_kind = 3'd0; tick("R6");

    // R5: completion before the data cycle cancels the request
    quiet(); lock_prefix = 1; tick("R5");
    quiet(); instr_done = 1; tick("R5");
    quiet(); data_start = 1; tick("R5"); expect_lock("R5", 0);
    quiet(); lock_prefix = 1; tick("R5");
    quiet(); data_start = 1; instr_done = 1; tick("R5");
    quiet(); data_start = 1; tick("R5"); expect_lock("R5", 0);

    // R10: release and re-arm in the same clock
    quiet(); lock_prefix = 1; tick("R10");
    quiet(); data_start = 1; tick("R10");
    quiet(); instr_done = 1; lock_prefix = 1; tick("R10"); expect_lock("R10", 0);
    quiet(); data_start = 1; tick("R10"); expect_lock("R10", 1);
    quiet(); instr_done = 1; tick("R10");
    quiet(); tick("R10");

    // random phase across all requirements
    for (int i = 0; i < 4000; i++) begin
      rst_n       = ($urandom_range(0, 199) != 0);
      cyc_go      = $urandom_range(0, 3) != 0;
      cyc_kind    = 3'($urandom_range(0, 7));
      lock_prefix = $urandom_range(0, 7) == 0;
      data_start  = $urandom_range(0, 3) == 0;
      instr_done  = $urandom_range(0, 5) == 0;
      tick("R1-mix R4 R6 R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule